// File: doc/BRIEF.md
# Serial ADC Conversion and Capture Sequencer

This block runs a serial successive-approximation converter through repeated conversions, all timed in steps of a fast pattern clock. For each sample it drives an active-low conversion request for a programmable number of steps. It then waits a programmable settling time. Next it lowers an active-low select and clocks out one data word, most significant bit first. On every serial clock period it raises an explicit bit-sample strobe, and the data line is shifted into a word register on that strobe. When the word is complete, it writes the word to an external capture memory through a one-step write strobe at an incrementing address. It then pulses a stimulus clock, so that an external ramp generator steps to its next level.

A run is launched by a one-cycle start pulse, which carries the number of samples to take. When that count is reached, a done flag rises and every converter and memory control returns to its idle level. The flag stays high until the next start. At the default pattern rate of one step per clock, the serial clock runs at half the clock frequency.

Top module: `serial_adc_seq`

## Requirements
- R1: After synchronous reset, conv_n and cs_n are 1, and sclk, bit_stb, cap_we, stim_clk and done are 0.
- R2: Each sample begins with conv_n low for max(conv_steps,1) consecutive steps, with cs_n high and no other strobe active.
- R3: After the conversion request, conv_n returns high and all strobes stay idle for max(wait_steps,1) steps before readout.
- R4: Readout holds cs_n low for exactly 2*DATA_W steps: DATA_W serial clock periods, each with sclk high in the first step and low in the second.
- R5: bit_stb is high in the second step of every serial clock period. The data line is sampled at the clock edge where bit_stb rises, and the first sampled bit becomes the word's most significant bit.
- R6: The step after readout has cap_we high for one step, with cs_n high. cap_data holds the assembled word, and cap_addr is the sample's index, counting from 0 at each start.
- R7: The step after the capture write has stim_clk high for one step. The next sample's conversion request follows in the step after that.
- R8: Once num_samples samples are complete, done is 1 and all other outputs sit at their R1 levels until a new start.
- R9: A start pulse that arrives while a run is in progress has no effect on the ongoing sequence.
- R10: A start with num_samples equal to 0 takes no samples and raises done in the next step.
- R11: The word register is cleared as each sample begins, so cap_data reads 0 throughout the conversion and wait phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pattern clock; one period is one step |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run |
| num_samples | input | ADDR_W+1 | Samples to take in the run, taken at start |
| conv_steps | input | STEP_W | Length of the conversion-request pulse in steps (0 acts as 1) |
| wait_steps | input | STEP_W | Wait between request and readout in steps (0 acts as 1) |
| sdata | input | 1 | Serial data line from the converter |
| conv_n | output | 1 | Active-low conversion request |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to the converter |
| bit_stb | output | 1 | Bit-sample strobe of the word register |
| cap_we | output | 1 | Capture memory write strobe |
| cap_addr | output | ADDR_W | Capture memory write address |
| cap_data | output | DATA_W | Assembled word for the capture memory |
| stim_clk | output | 1 | Stimulus advance strobe |
| done | output | 1 | High once the run is complete |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=6 and STEP_W=4. With a 4-bit step field, the largest programmable pulse (15 steps) and the zero-treated-as-one case can both be tried in a short run, and the small address keeps runs brief. The converter model returns a fixed code list that includes all-ones, all-zeros and single-bit patterns, so a bit-order or shift-length error shows up in the captured words. The runs cover a zero-sample start, a start pulsed mid-run, and a restart from the done state.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_SCK_HI,
    ST_SCK_LO,
    ST_CAPT,
    ST_STIM,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic conv_n;
    logic cs_n;
    logic sclk;
    logic bit_stb;
    logic cap_we;
    logic stim_clk;
    logic done;
  } pins_t;

  // Output levels that belong to each sequencer state
  function automatic pins_t pins_of(seq_state_e s);
    pins_t p;
    p.conv_n   = (s != ST_CONV);
    p.cs_n     = !((s == ST_SCK_HI) || (s == ST_SCK_LO));
    p.sclk     = (s == ST_SCK_HI);
    p.bit_stb  = (s == ST_SCK_LO);
    p.cap_we   = (s == ST_CAPT);
    p.stim_clk = (s == ST_STIM);
    p.done     = (s == ST_DONE);
    return p;
  endfunction

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   num_samples,
  input  logic [STEP_W-1:0] conv_steps,
  input  logic [STEP_W-1:0] wait_steps,
  output pins_t             pins_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              shift_en,
  output logic              shift_clr
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [STEP_W-1:0] ONE_STEP = STEP_W'(1);

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [ADDR_W:0]   left_q, left_d;
  logic [ADDR_W-1:0] addr_d;
  logic [STEP_W-1:0] conv_len, wait_len;

  assign conv_len = (conv_steps == '0) ? ONE_STEP : conv_steps;
  assign wait_len = (wait_steps == '0) ? ONE_STEP : wait_steps;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    left_d = left_q;
    addr_d = addr_q;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          left_d = num_samples;
          addr_d = '0;
          if (num_samples == '0) begin
            st_d = ST_DONE;
          end else begin
            st_d  = ST_CONV;
            cnt_d = conv_len;
          end
        end
      end
      ST_CONV: begin
        if (cnt_q <= ONE_STEP) begin
          st_d  = ST_WAIT;
          cnt_d = wait_len;
        end else begin
          cnt_d = cnt_q - ONE_STEP;
        end
      end
      ST_WAIT: begin
        if (cnt_q <= ONE_STEP) begin
          st_d  = ST_SCK_HI;
          bit_d = '0;
        end else begin
          cnt_d = cnt_q - ONE_STEP;
        end
      end
      ST_SCK_HI: st_d = ST_SCK_LO;
      ST_SCK_LO: begin
        if (bit_q == LAST_BIT) begin
          st_d = ST_CAPT;
        end else begin
          bit_d = bit_q + 1'b1;
          st_d  = ST_SCK_HI;
        end
      end
      ST_CAPT: st_d = ST_STIM;
      ST_STIM: begin
        addr_d = addr_q + 1'b1;
        left_d = left_q - 1'b1;
        if (left_q <= (ADDR_W+1)'(1)) begin
          st_d = ST_DONE;
        end else begin
          st_d  = ST_CONV;
          cnt_d = conv_len;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Word register controls follow the next state, so they line up with the registered pins
  assign shift_en  = (st_d == ST_SCK_LO);
  assign shift_clr = (st_d == ST_CONV) && (st_q != ST_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      left_q <= '0;
      addr_q <= '0;
      pins_q <= pins_of(ST_IDLE);
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      left_q <= left_d;
      addr_q <= addr_d;
      pins_q <= pins_of(st_d);
    end
  end

endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              sdata,
  output logic [DATA_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word_q <= '0;
    end else if (en) begin
      word_q <= {word_q[DATA_W-2:0], sdata};
    end
  end

endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq
  import adcseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   num_samples,
  input  logic [STEP_W-1:0] conv_steps,
  input  logic [STEP_W-1:0] wait_steps,
  input  logic              sdata,
  output logic              conv_n,
  output logic              cs_n,
  output logic              sclk,
  output logic              bit_stb,
  output logic              cap_we,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              stim_clk,
  output logic              done
);

  pins_t pins;
  logic  shift_en;
  logic  shift_clr;

  adcseq_ctrl #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .STEP_W(STEP_W)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .num_samples(num_samples),
    .conv_steps (conv_steps),
    .wait_steps (wait_steps),
    .pins_q     (pins),
    .addr_q     (cap_addr),
    .shift_en   (shift_en),
    .shift_clr  (shift_clr)
  );

  adcseq_shifter #(
    .DATA_W(DATA_W)
  ) shift_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (shift_clr),
    .en    (shift_en),
    .sdata (sdata),
    .word_q(cap_data)
  );

  assign conv_n   = pins.conv_n;
  assign cs_n     = pins.cs_n;
  assign sclk     = pins.sclk;
  assign bit_stb  = pins.bit_stb;
  assign cap_we   = pins.cap_we;
  assign stim_clk = pins.stim_clk;
  assign done     = pins.done;

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              bit_stb,
  input logic              cap_we,
  input logic [ADDR_W-1:0] cap_addr,
  input logic              stim_clk,
  input logic              done
);

  // R2: at most one of the per-step activities at a time
  p_single_phase_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!conv_n, sclk, bit_stb, cap_we, stim_clk, done}));

  // R4: the serial clock only toggles inside the select window
  p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  // R5: the sample strobe always follows a high serial clock step
  p_strobe_after_sclk_r5: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> (!cs_n && $past(sclk)));

  // R6: a capture write comes right after the last bit strobe, with select released
  p_write_after_bits_r6: assert property (@(posedge clk) disable iff (rst)
    cap_we |-> (cs_n && $past(bit_stb)));

  // R7: stimulus strobe follows each capture write
  p_stim_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    cap_we |=> stim_clk);

  // R6: write address advances by one after each stimulus step
  p_addr_advance_r6: assert property (@(posedge clk) disable iff (rst)
    stim_clk |=> (cap_addr == $past(cap_addr) + 1'b1));

  // R8: everything idle while done
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (conv_n && cs_n && !sclk && !bit_stb && !cap_we && !stim_clk));

endmodule

bind serial_adc_seq adcseq_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .conv_n  (conv_n),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .bit_stb (bit_stb),
  .cap_we  (cap_we),
  .cap_addr(cap_addr),
  .stim_clk(stim_clk),
  .done    (done)
);

// File: tb/serial_adc_seq_tb_top.sv
module serial_adc_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int STEP_W = 4;

  localparam int K_CONV = 0, K_WAIT = 1, K_HI = 2, K_LO = 3,
                 K_CAPT = 4, K_STIM = 5, K_DONE = 6, K_IDLE = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W:0]   num_samples = '0;
  logic [STEP_W-1:0] conv_steps = '0;
  logic [STEP_W-1:0] wait_steps = '0;
  logic              sdata = 1'b0;
  logic              conv_n, cs_n, sclk, bit_stb, cap_we, stim_clk, done;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int code_idx = 0;
  int cap_idx = 0;
  int kind_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_adc_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .num_samples(num_samples),
    .conv_steps(conv_steps), .wait_steps(wait_steps), .sdata(sdata),
    .conv_n(conv_n), .cs_n(cs_n), .sclk(sclk), .bit_stb(bit_stb),
    .cap_we(cap_we), .cap_addr(cap_addr), .cap_data(cap_data),
    .stim_clk(stim_clk), .done(done)
  );

  function automatic logic [DATA_W-1:0] code_of(int k);
    case (k)
      0:       return 16'h8001;
      1:       return 16'hFFFF;
      2:       return 16'h0000;
      3:       return 16'h7FFE;
      default: return 16'((k * 40503) ^ 23130);
    endcase
  endfunction

  // Behavioural converter: new word on each select, next bit shortly after each sclk rise, MSB first
  logic [DATA_W-1:0] conv_word = '0;
  int bit_pos = DATA_W - 1;
  always @(negedge cs_n) begin
    conv_word = code_of(code_idx);
    code_idx++;
    bit_pos = DATA_W - 1;
  end
  always @(posedge sclk) begin
    #1;
    if (bit_pos >= 0) sdata = conv_word[bit_pos];
    bit_pos--;
  end

  function automatic logic [6:0] vec_of(int k);
    case (k)
      K_CONV:  return 7'b0100000;
      K_WAIT:  return 7'b1100000;
      K_HI:    return 7'b1010000;
      K_LO:    return 7'b1001000;
      K_CAPT:  return 7'b1100100;
      K_STIM:  return 7'b1100010;
      K_DONE:  return 7'b1100001;
      default: return 7'b1100000;
    endcase
  endfunction

  function automatic string tag_of(int k, bit zero_run);
    case (k)
      K_CONV:  return "R2";
      K_WAIT:  return "R3";
      K_HI:    return "R4";
      K_LO:    return "R5";
      K_CAPT:  return "R6";
      K_STIM:  return "R7";
      K_DONE:  return zero_run ? "R10" : "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check_cycle(input int k, input int sidx, input bit zero_run);
    logic [6:0] got;
    logic [6:0] exp;
    logic [DATA_W-1:0] want;
    got = {conv_n, cs_n, sclk, bit_stb, cap_we, stim_clk, done};
    exp = vec_of(k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pins {conv_n,cs_n,sclk,bit_stb,cap_we,stim_clk,done} actual %b expected %b",
               tag_of(k, zero_run), got, exp);
    end
    if (k == K_CAPT) begin
      want = code_of(cap_idx);
      cap_idx++;
      checks++;
      if (cap_data !== want) begin
        errors++;
        $display("FAIL R5 cap_data actual %h expected %h", cap_data, want);
      end
      checks++;
      if (cap_addr !== ADDR_W'(sidx)) begin
        errors++;
        $display("FAIL R6 cap_addr actual %0d expected %0d", cap_addr, sidx);
      end
    end
    if (k == K_CONV || k == K_WAIT) begin
      checks++;
      if (cap_data !== '0) begin
        errors++;
        $display("FAIL R11 cap_data actual %h expected 0000", cap_data);
      end
    end
  endtask

  // Builds the expected step stream, launches a run and compares every clock
  task automatic run_seq(input int lo, input int wt, input int n, input bit poke);
    int l;
    int w;
    int k;
    int sidx;
    l = (lo == 0) ? 1 : lo;
    w = (wt == 0) ? 1 : wt;
    sidx = 0;
    kind_q.delete();
    for (int s = 0; s < n; s++) begin
      repeat (l) kind_q.push_back(K_CONV);
      repeat (w) kind_q.push_back(K_WAIT);
      for (int b = 0; b < DATA_W; b++) begin
        kind_q.push_back(K_HI);
        kind_q.push_back(K_LO);
      end
      kind_q.push_back(K_CAPT);
      kind_q.push_back(K_STIM);
    end
    @(negedge clk);
    conv_steps  = STEP_W'(lo);
    wait_steps  = STEP_W'(wt);
    num_samples = (ADDR_W+1)'(n);
    start = 1'b1;
    for (int c = 0; c < kind_q.size() + 4; c++) begin
      @(negedge clk);
      k = (c < kind_q.size()) ? kind_q[c] : K_DONE;
      check_cycle(k, sidx, n == 0);
      if (k == K_STIM) sidx++;
      // R9: a second start during the run must leave the stream unchanged
      start = (poke && c == 7) ? 1'b1 : 1'b0;
      if (poke && c == 7) num_samples = (ADDR_W+1)'(1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle levels after reset
    repeat (3) begin
      @(negedge clk);
      check_cycle(K_IDLE, 0, 1'b0);
    end
    run_seq(2, 3, 0, 1'b0);   // R10: zero samples
    run_seq(1, 1, 4, 1'b1);   // shortest phases, start pulsed mid-run
    run_seq(15, 3, 3, 1'b0);  // longest request pulse, restart from done
    run_seq(0, 0, 2, 1'b0);   // zero lengths act as one step
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule